// File: doc/BRIEF.md
# Baud Rate Clock Prescaler Chain

This block derives every clock enable a serial channel needs from one system clock. A pin-level rate tick is taken from one of three sources: a tick from an upstream fractional divider, the rising edges of an external trigger pulse, or the rising edges of an external level input. A bypassable 2:1 stage turns the pin-level tick into the pre-processing tick and also forms the master clock. A 10-bit programmable divider turns pre-processing ticks into a divided tick, which also toggles an internal shift clock. A time-quanta counter, built from a pre-divider and a denominator stage, counts ticks from one of four selectable sources.

All ticks are single-cycle enables in the system clock domain. The external inputs are asynchronous and pass through a two-flop synchronizer before any edge is taken. The block is steered entirely by a 32-bit configuration word that is sampled every cycle. The fractional divider and the serial shift logic sit outside the block.

Top module: `rate_clock_chain`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all four tick outputs are 0. `mclk_out` equals configuration bit 22 and `sclk_out` equals configuration bit 23.
- R2: Source code 0 in configuration bits [1:0] gives one `pin_tick` for each cycle `frac_tick` is high, one cycle later.
- R3: Source code 2 gives one `pin_tick` per rising edge of `ext_trig` and ignores `frac_tick`. In codes 0 and 2 the master clock toggles on every pin tick: after N pin ticks since reset, `mclk_out` = (N mod 2) XOR bit 22.
- R4: Source code 3 gives one `pin_tick` per rising edge of `ext_level`, and `mclk_out` follows the synchronized `ext_level` XOR bit 22.
- R5: Source code 1 is reserved. It produces no `pin_tick`, whatever the inputs do, so the master clock keeps its level.
- R6: With bit 2 clear, `pre_tick` repeats every `pin_tick` one cycle later. With bit 2 set, only every second pin tick since reset passes, so N pin ticks give floor(N/2) pre ticks and two pre ticks are never adjacent.
- R7: With divider factor F in bits [21:12], one `div_tick` comes out for every F+1 pre ticks. N pre ticks after reset give floor(N/(F+1)) divided ticks, and F = 0 passes every pre tick.
- R8: Bits [4:3] select the time-quanta input: 0 = divided tick, 1 = pre-processing tick, 2 = rising edge of the shift clock, 3 = rising edge of the master clock.
- R9: With pre-divider P in bits [6:5] and denominator D in bits [11:7], one `tq_tick` comes out per (P+1)*(D+1) selected input ticks.
- R10: Bit 22 sets the master clock idle level. Setting it inverts `mclk_out` in every source mode.
- R11: The internal shift clock toggles on every `div_tick`. With bit 24 clear and bit 25 clear, `sclk_out` = (divided ticks since reset mod 2) XOR bit 23.
- R12: With bit 24 set, the internal shift clock reaches `sclk_out` one divided tick late, which is half a shift clock period.
- R13: With bit 25 set, `sclk_out` is the synchronized `ext_shift_clk` XOR bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration word |
| frac_tick | input | 1 | Tick from the upstream fractional divider |
| ext_trig | input | 1 | Asynchronous external trigger pulse |
| ext_level | input | 1 | Asynchronous external level input |
| ext_shift_clk | input | 1 | Asynchronous externally supplied transmit shift clock |
| pin_tick | output | 1 | Pin-level rate tick |
| pre_tick | output | 1 | Pre-processing tick after the 2:1 stage |
| div_tick | output | 1 | Divided tick |
| tq_tick | output | 1 | Time-quanta tick |
| mclk_out | output | 1 | Master clock output |
| sclk_out | output | 1 | Shift clock output |

## Verification
Two events that can fall in the same cycle are the time-quanta pre-divider wrap and the denominator wrap. The same holds for a divider wrap landing on the cycle in which a new pre tick arrives. Both cases are forced by holding `frac_tick` high every cycle with small pre-divider, denominator and factor values, including zeros, so that every input tick wraps one or both stages at once. Each case is judged by comparing the tick counts on every output against floor-division results computed in the bench from the requirement formulas, across sweeps of all four time-quanta sources.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    localparam int CFG_W    = 32;
    localparam int FACTOR_W = 10;
    localparam int TQ_PRE_W = 2;
    localparam int TQ_DEN_W = 5;
    localparam int SPARE_W  = CFG_W - (FACTOR_W + TQ_PRE_W + TQ_DEN_W + 9);

    // indices of the asynchronous inputs inside the synchronizer vector
    localparam int ASYNC_N   = 3;
    localparam int IDX_TRIG  = 0;
    localparam int IDX_LEVEL = 1;
    localparam int IDX_SHIFT = 2;

    typedef enum logic [1:0] {
        SRC_FRAC  = 2'd0,
        SRC_RSVD  = 2'd1,
        SRC_TRIG  = 2'd2,
        SRC_LEVEL = 2'd3
    } rate_src_e;

    typedef enum logic [1:0] {
        TQ_DIV    = 2'd0,
        TQ_PRE    = 2'd1,
        TQ_SHIFT  = 2'd2,
        TQ_MASTER = 2'd3
    } tq_src_e;

    typedef struct packed {
        logic [SPARE_W-1:0]  spare;      // 31:26
        logic                sclk_ext;   // 25
        logic                sclk_delay; // 24
        logic                sclk_idle;  // 23
        logic                mclk_idle;  // 22
        logic [FACTOR_W-1:0] factor;     // 21:12
        logic [TQ_DEN_W-1:0] tq_den;     // 11:7
        logic [TQ_PRE_W-1:0] tq_pre;     // 6:5
        tq_src_e             tq_src;     // 4:3
        logic                half_en;    // 2
        rate_src_e           src;        // 1:0
    } cfg_t;

    function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        return cfg_t'(w);
    endfunction

    function automatic logic pick_tq(input tq_src_e s, input logic d_tick,
                                     input logic p_tick, input logic s_rise,
                                     input logic m_rise);
        case (s)
            TQ_DIV:   return d_tick;
            TQ_PRE:   return p_tick;
            TQ_SHIFT: return s_rise;
            default:  return m_rise;
        endcase
    endfunction
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise
);
    localparam int DEPTH = STAGES + 1;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [DEPTH-1:0] shreg;
        always_ff @(posedge clk) begin
            if (rst) shreg <= '0;
            else     shreg <= {shreg[DEPTH-2:0], async_in[i]};
        end
        assign level[i] = shreg[STAGES-1];
        assign rise[i]  = shreg[STAGES-1] & ~shreg[STAGES];
    end
endmodule

// File: rtl/rcc_modcnt.sv
module rcc_modcnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] cnt;

    // greater-or-equal lets a lowered limit recover at once
    assign wrap = en & (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (wrap) cnt <= '0;
        else if (en)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rcc_src_stage.sv
module rcc_src_stage
    import rcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rate_src_e src,
    input  logic      half_en,
    input  logic      frac_tick,
    input  logic      trig_rise,
    input  logic      level_rise,
    input  logic      level_sync,
    output logic      pin_tick,
    output logic      pre_tick,
    output logic      mclk_raw,
    output logic      mclk_rise
);
    logic sel_tick;
    logic phase;
    logic level_q;
    logic mclk_prev;

    always_comb begin
        case (src)
            SRC_FRAC:  sel_tick = frac_tick;
            SRC_TRIG:  sel_tick = trig_rise;
            SRC_LEVEL: sel_tick = level_rise;
            default:   sel_tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_tick  <= 1'b0;
            pre_tick  <= 1'b0;
            phase     <= 1'b0;
            level_q   <= 1'b0;
            mclk_prev <= 1'b0;
        end else begin
            pin_tick  <= sel_tick;
            pre_tick  <= half_en ? (pin_tick & phase) : pin_tick;
            if (pin_tick) phase <= ~phase;
            level_q   <= level_sync;
            mclk_prev <= mclk_raw;
        end
    end

    assign mclk_raw  = (src == SRC_LEVEL) ? level_q : phase;
    assign mclk_rise = mclk_raw & ~mclk_prev;
endmodule

// File: rtl/rcc_shift_stage.sv
module rcc_shift_stage (
    input  logic clk,
    input  logic rst,
    input  logic div_tick,
    input  logic ext_sel,
    input  logic idle_level,
    input  logic delay_en,
    input  logic ext_level,
    input  logic ext_rise,
    output logic sclk_out,
    output logic sclk_rise
);
    logic phase;
    logic phase_lag;
    logic int_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= 1'b0;
            phase_lag <= 1'b0;
        end else if (div_tick) begin
            phase     <= ~phase;
            phase_lag <= phase;
        end
    end

    assign int_clk   = delay_en ? phase_lag : phase;
    assign sclk_out  = (ext_sel ? ext_level : int_clk) ^ idle_level;
    assign sclk_rise = ext_sel ? ext_rise : (div_tick & ~phase);
endmodule

// File: rtl/rate_clock_chain.sv
module rate_clock_chain
    import rcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             frac_tick,
    input  logic             ext_trig,
    input  logic             ext_level,
    input  logic             ext_shift_clk,
    output logic             pin_tick,
    output logic             pre_tick,
    output logic             div_tick,
    output logic             tq_tick,
    output logic             mclk_out,
    output logic             sclk_out
);
    cfg_t cfg;
    assign cfg = decode_cfg(cfg_word);

    logic unused_spare;
    assign unused_spare = ^cfg.spare;

    logic [ASYNC_N-1:0] async_vec, sync_level, sync_rise;
    assign async_vec[IDX_TRIG]  = ext_trig;
    assign async_vec[IDX_LEVEL] = ext_level;
    assign async_vec[IDX_SHIFT] = ext_shift_clk;

    rcc_sync #(.N(ASYNC_N), .STAGES(2)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (async_vec),
        .level    (sync_level),
        .rise     (sync_rise)
    );

    logic mclk_raw, mclk_rise;

    rcc_src_stage i_src (
        .clk        (clk),
        .rst        (rst),
        .src        (cfg.src),
        .half_en    (cfg.half_en),
        .frac_tick  (frac_tick),
        .trig_rise  (sync_rise[IDX_TRIG]),
        .level_rise (sync_rise[IDX_LEVEL]),
        .level_sync (sync_level[IDX_LEVEL]),
        .pin_tick   (pin_tick),
        .pre_tick   (pre_tick),
        .mclk_raw   (mclk_raw),
        .mclk_rise  (mclk_rise)
    );

    assign mclk_out = mclk_raw ^ cfg.mclk_idle;

    // programmable divider on the pre-processing tick
    logic div_wrap;
    rcc_modcnt #(.W(FACTOR_W)) i_div (
        .clk   (clk),
        .rst   (rst),
        .en    (pre_tick),
        .limit (cfg.factor),
        .wrap  (div_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) div_tick <= 1'b0;
        else     div_tick <= div_wrap;
    end

    logic sclk_rise;
    rcc_shift_stage i_shift (
        .clk        (clk),
        .rst        (rst),
        .div_tick   (div_tick),
        .ext_sel    (cfg.sclk_ext),
        .idle_level (cfg.sclk_idle),
        .delay_en   (cfg.sclk_delay),
        .ext_level  (sync_level[IDX_SHIFT]),
        .ext_rise   (sync_rise[IDX_SHIFT]),
        .sclk_out   (sclk_out),
        .sclk_rise  (sclk_rise)
    );

    // time-quanta counter: pre-divider then denominator
    logic tq_in, pre_wrap, den_wrap;
    assign tq_in = pick_tq(cfg.tq_src, div_tick, pre_tick, sclk_rise, mclk_rise);

    rcc_modcnt #(.W(TQ_PRE_W)) i_tq_pre (
        .clk   (clk),
        .rst   (rst),
        .en    (tq_in),
        .limit (cfg.tq_pre),
        .wrap  (pre_wrap)
    );

    rcc_modcnt #(.W(TQ_DEN_W)) i_tq_den (
        .clk   (clk),
        .rst   (rst),
        .en    (pre_wrap),
        .limit (cfg.tq_den),
        .wrap  (den_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) tq_tick <= 1'b0;
        else     tq_tick <= den_wrap;
    end
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker
    import rcc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CFG_W-1:0] cfg_word,
    input logic             pin_tick,
    input logic             pre_tick,
    input logic             div_tick,
    input logic             tq_tick
);
    cfg_t c;
    assign c = decode_cfg(cfg_word);

    p_reserved_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (c.src == SRC_RSVD) |=> !pin_tick);

    p_pre_from_pin_r6: assert property (@(posedge clk) disable iff (rst)
        pre_tick |-> $past(pin_tick));

    p_half_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        (pre_tick && c.half_en && $past(c.half_en)) |=> !pre_tick);

    p_div_from_pre_r7: assert property (@(posedge clk) disable iff (rst)
        div_tick |-> $past(pre_tick));

    p_div_unity_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(c.factor) == '0 && $past(pre_tick)) |-> div_tick);

    p_tq_from_pre_r9: assert property (@(posedge clk) disable iff (rst)
        (tq_tick && $past(c.tq_src) == TQ_PRE) |-> $past(pre_tick));
endmodule

bind rate_clock_chain rcc_checker i_rcc_checker (
    .clk      (clk),
    .rst      (rst),
    .cfg_word (cfg_word),
    .pin_tick (pin_tick),
    .pre_tick (pre_tick),
    .div_tick (div_tick),
    .tq_tick  (tq_tick)
);

// File: tb/test_rate_clock_chain.sv
`timescale 1ns/1ps
module test_rate_clock_chain;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        frac_tick = 1'b0;
    logic        ext_trig = 1'b0;
    logic        ext_level = 1'b0;
    logic        ext_shift_clk = 1'b0;
    logic        pin_tick, pre_tick, div_tick, tq_tick, mclk_out, sclk_out;

    int errors = 0;
    int checks = 0;
    int n_pin = 0, n_pre = 0, n_div = 0, n_tq = 0;

    always #10 clk = ~clk;

    rate_clock_chain i_rate_clock_chain (
        .clk           (clk),
        .rst           (rst),
        .cfg_word      (cfg_word),
        .frac_tick     (frac_tick),
        .ext_trig      (ext_trig),
        .ext_level     (ext_level),
        .ext_shift_clk (ext_shift_clk),
        .pin_tick      (pin_tick),
        .pre_tick      (pre_tick),
        .div_tick      (div_tick),
        .tq_tick       (tq_tick),
        .mclk_out      (mclk_out),
        .sclk_out      (sclk_out)
    );

    always @(negedge clk) begin
        if (rst) begin
            n_pin = 0; n_pre = 0; n_div = 0; n_tq = 0;
        end else begin
            n_pin = n_pin + int'(pin_tick);
            n_pre = n_pre + int'(pre_tick);
            n_div = n_div + int'(div_tick);
            n_tq  = n_tq  + int'(tq_tick);
        end
    end

    function automatic logic [31:0] mk_cfg(int src, int half, int tsrc, int pre, int den,
                                           int factor, int midle, int sidle, int sdel, int sext);
        logic [31:0] w;
        w = '0;
        w[1:0]   = src[1:0];
        w[2]     = half[0];
        w[4:3]   = tsrc[1:0];
        w[6:5]   = pre[1:0];
        w[11:7]  = den[4:0];
        w[21:12] = factor[9:0];
        w[22]    = midle[0];
        w[23]    = sidle[0];
        w[24]    = sdel[0];
        w[25]    = sext[0];
        return w;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(logic [31:0] w);
        @(negedge clk);
        cfg_word = w;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic frac_burst(int n);
        frac_tick = 1'b1;
        repeat (n) @(negedge clk);
        frac_tick = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic pulse_trig(int n);
        for (int k = 0; k < n; k++) begin
            ext_trig = 1'b1; repeat (4) @(negedge clk);
            ext_trig = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_level(int n);
        for (int k = 0; k < n; k++) begin
            ext_level = 1'b1; repeat (4) @(negedge clk);
            ext_level = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state with both idle bits set
        @(negedge clk);
        cfg_word = mk_cfg(0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        repeat (2) @(negedge clk);
        check("R1 pin_tick in reset", int'(pin_tick), 0);
        check("R1 tq_tick in reset", int'(tq_tick), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pre/div after reset", int'(pre_tick) + int'(div_tick), 0);
        check("R1 mclk_out idle", int'(mclk_out), 1);
        check("R1 sclk_out idle", int'(sclk_out), 1);

        // R2 R3 R6 R7 R11: factor and half-rate sweep, source 0
        for (int f = 0; f < 8; f++) begin
            for (int h = 0; h < 2; h++) begin
                int n, ep, ed;
                n = 37;
                ep = (h != 0) ? n / 2 : n;
                ed = ep / (f + 1);
                do_reset(mk_cfg(0, h, 0, 0, 0, f, 0, 0, 0, 0));
                frac_burst(n);
                check("R2 pin count", n_pin, n);
                check("R6 pre count", n_pre, ep);
                check("R7 div count", n_div, ed);
                check("R8 tq from divided tick", n_tq, ed);
                check("R3 mclk after frac ticks", int'(mclk_out), n % 2);
                check("R11 internal sclk level", int'(sclk_out), ed % 2);
            end
        end

        // R8 R9: time-quanta source, pre-divider and denominator sweep
        for (int ts = 0; ts < 4; ts++) begin
            for (int p = 0; p < 4; p++) begin
                for (int d = 0; d < 4; d++) begin
                    int n, ein, exp_in[4];
                    n = 53;
                    exp_in[0] = n / 2;              // divided ticks, factor 1
                    exp_in[1] = n;                  // pre ticks
                    exp_in[2] = (n / 2 + 1) / 2;    // shift clock rising edges
                    exp_in[3] = (n + 1) / 2;        // master clock rising edges
                    ein = exp_in[ts];
                    do_reset(mk_cfg(0, 0, ts, p, d, 1, 0, 0, 0, 0));
                    frac_burst(n);
                    check("R9 tq count", n_tq, ein / ((p + 1) * (d + 1)));
                end
            end
        end

        // R5 R10: reserved source, idle level 1
        do_reset(mk_cfg(1, 0, 1, 0, 0, 0, 1, 0, 0, 0));
        ext_trig = 1'b1;
        frac_burst(20);
        ext_trig = 1'b0;
        check("R5 reserved source pin count", n_pin, 0);
        check("R10 mclk held at idle 1", int'(mclk_out), 1);

        // R3 R10: trigger source, frac held high must not count
        do_reset(mk_cfg(2, 0, 0, 0, 0, 0, 1, 0, 0, 0));
        frac_tick = 1'b1;
        pulse_trig(5);
        frac_tick = 1'b0;
        check("R3 trigger pin count", n_pin, 5);
        check("R3 R10 mclk after 5 toggles idle 1", int'(mclk_out), 0);

        // R4: level source
        do_reset(mk_cfg(3, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        pulse_level(4);
        check("R4 level rising edge count", n_pin, 4);
        check("R4 mclk follows low level", int'(mclk_out), 0);
        ext_level = 1'b1;
        repeat (8) @(negedge clk);
        check("R4 mclk follows high level", int'(mclk_out), 1);
        check("R4 one more rising edge", n_pin, 5);
        do_reset(mk_cfg(3, 0, 0, 0, 0, 0, 1, 0, 0, 0));
        repeat (8) @(negedge clk);
        check("R10 mclk inverted in level mode", int'(mclk_out), 0);
        ext_level = 1'b0;

        // R11 R12: shift clock delay, 5 divided ticks
        do_reset(mk_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        frac_burst(5);
        check("R11 sclk without delay", int'(sclk_out), 1);
        do_reset(mk_cfg(0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        frac_burst(5);
        check("R12 sclk with delay", int'(sclk_out), 0);
        do_reset(mk_cfg(0, 0, 0, 0, 0, 0, 0, 1, 1, 0));
        frac_burst(5);
        check("R12 sclk delay idle 1", int'(sclk_out), 1);

        // R13: external shift clock routed out
        do_reset(mk_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        ext_shift_clk = 1'b1;
        repeat (6) @(negedge clk);
        check("R13 ext shift clock high", int'(sclk_out), 1);
        ext_shift_clk = 1'b0;
        repeat (6) @(negedge clk);
        check("R13 ext shift clock low", int'(sclk_out), 0);
        cfg_word = mk_cfg(0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        ext_shift_clk = 1'b1;
        repeat (6) @(negedge clk);
        check("R13 ext shift clock inverted", int'(sclk_out), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule